// File: doc/BRIEF.md
# Circular Convolution Engine

This block computes the circular convolution of two signed integer sequences kept in two on-chip buffers. Each sequence has its own length, set by a configuration write that also rewinds that sequence's write pointer. The samples are then pushed one at a time. The working length N of a run is the larger of the two lengths. Positions of the shorter sequence at or beyond its own length count as zero, so it is padded without any memory being cleared.

A start pulse launches a run. For each output index k, the engine walks i from 0 to N-1 and multiplies the first sequence at i by the second sequence at (k-i) mod N. This is the same as folding the second sequence and rotating it right by one place for every new output. One product is accumulated per clock, in an accumulator wide enough that no partial sum can overflow. Each finished sum leaves on a registered valid strobe, and the final one of the run also raises a last flag. While a run is in progress, starts, configuration writes and sample writes are all ignored.

Top module: `circ_conv_engine`

## Requirements
- R1: After a synchronous reset, busy, err, out_valid and out_last are all low, and both stored lengths are zero.
- R2: A configuration write with cfg_sel=0 sets the length of the first sequence and cfg_sel=1 sets the length of the second. Values 1..MAX_LEN are accepted and rewind that sequence's write pointer. Each later sample write with the same select stores the next element, starting at index 0.
- R3: A configuration length of 0 or above MAX_LEN pulses err high in the cycle after the write and leaves both stored lengths and their contents unchanged.
- R4: A run produces exactly N = max(first length, second length) output samples. The shorter sequence is treated as zero beyond its length, and out_last is high on the Nth sample and on no other.
- R5: Output k equals the sum over i in 0..N-1 of first[i]*second[(k-i) mod N]. For first = 1,2,3,4 and second = 1,2,3 the outputs are 18, 16, 10, 16.
- R6: Operands are two's-complement, and out_data is 2*W+clog2(MAX_LEN) bits wide, so sums of MAX_LEN extreme products come out exact.
- R7: While busy is high, start, configuration writes and sample writes have no effect on the current run or on the stored sequences, and no err pulse is raised.
- R8: A start pulse while both stored lengths are zero is ignored: busy stays low and no output appears.
- R9: Sample writes beyond a sequence's configured length are discarded, and the elements already stored are kept.
- R10: out_valid is raised only during a run. busy goes low in the same cycle that the last output sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Length configuration write strobe |
| cfg_sel | input | 1 | Sequence chosen by the configuration write (0 first, 1 second) |
| cfg_len | input | clog2(MAX_LEN+1) | Requested length |
| smp_valid | input | 1 | Sample write strobe |
| smp_sel | input | 1 | Sequence chosen by the sample write (0 first, 1 second) |
| smp_data | input | W | Signed sample value |
| start | input | 1 | Launch a run |
| busy | output | 1 | Run in progress |
| err | output | 1 | One-cycle pulse for a rejected length |
| out_valid | output | 1 | out_data holds an output sample |
| out_data | output | 2*W+clog2(MAX_LEN) | Signed output sample |
| out_last | output | 1 | Marks the final sample of a run |

## Verification
The hardest case to reach from the ports is a control write that lands in the middle of a run. The task that covers it raises start, a configuration write and a sample write together, several cycles after launch. It then checks that the current outputs still match the model, and a second, undisturbed run shows that the stored lengths and data did not change. Two other cases need specific stimulus. Zero padding is exercised with sequences of unequal length in both directions. Overflow headroom needs maximum-length sequences made entirely of the most negative value, so that every product is as large as it can be.

// File: rtl/circ_conv_pkg.sv
package circ_conv_pkg;
  typedef enum logic {
    SEQ_FIRST  = 1'b0,
    SEQ_SECOND = 1'b1
  } seq_sel_e;

  localparam int NUM_SEQ = 2;
endpackage

// File: rtl/seq_buffer.sv
module seq_buffer #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/index_gen.sv
module index_gen #(
  parameter int MAX_LEN = 32,
  parameter int IDX_W   = 5,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [LEN_W-1:0] n,
  output logic             active,
  output logic [IDX_W-1:0] x_idx,
  output logic [IDX_W-1:0] h_idx,
  output logic             first,
  output logic             last_i,
  output logic             last_k
);
  logic [IDX_W-1:0] k_q, i_q;
  logic [LEN_W-1:0] n_m1;

  assign n_m1   = n - LEN_W'(1);
  assign x_idx  = i_q;
  assign first  = (i_q == '0);
  assign last_i = (LEN_W'(i_q) == n_m1);
  assign last_k = (LEN_W'(k_q) == n_m1);

  // (k - i) mod n; the wrap branch is exact modulo 2^LEN_W and ends below n
  always_comb begin
    if (k_q >= i_q) h_idx = k_q - i_q;
    else            h_idx = IDX_W'(LEN_W'(k_q) + n - LEN_W'(i_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      k_q    <= '0;
      i_q    <= '0;
    end else if (launch) begin
      active <= 1'b1;
      k_q    <= '0;
      i_q    <= '0;
    end else if (active) begin
      if (last_i) begin
        i_q <= '0;
        if (last_k) active <= 1'b0;
        else        k_q    <= k_q + IDX_W'(1);
      end else begin
        i_q <= i_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int W     = 8,
  parameter int ACC_W = 21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic                    first,
  input  logic                    last_i,
  input  logic                    last_k,
  input  logic signed [W-1:0]     a,
  input  logic signed [W-1:0]     b,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data,
  output logic                    out_last
);
  logic signed [2*W-1:0]   prod;
  logic signed [ACC_W-1:0] prod_ext, base, sum;
  logic signed [ACC_W-1:0] acc;

  assign prod     = a * b;
  assign prod_ext = {{(ACC_W-2*W){prod[2*W-1]}}, prod};
  assign base     = first ? '0 : acc;
  assign sum      = base + prod_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= in_v && last_i;
      out_last  <= in_v && last_i && last_k;
      if (in_v) begin
        acc <= sum;
        if (last_i) out_data <= sum;
      end
    end
  end
endmodule

// File: rtl/circ_conv_engine.sv
module circ_conv_engine
  import circ_conv_pkg::*;
#(
  parameter int W       = 8,
  parameter int MAX_LEN = 32,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int ACC_W  = 2 * W + $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic             cfg_sel,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             smp_valid,
  input  logic             smp_sel,
  input  logic [W-1:0]     smp_data,
  input  logic             start,
  output logic             busy,
  output logic             err,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_data,
  output logic             out_last
);
  logic [LEN_W-1:0] len_q [NUM_SEQ];
  logic [LEN_W-1:0] wp_q  [NUM_SEQ];
  logic             buf_we [NUM_SEQ];
  logic [IDX_W-1:0] buf_raddr [NUM_SEQ];
  logic [W-1:0]     buf_rdata [NUM_SEQ];

  logic [LEN_W-1:0] n_calc, n_reg;
  logic             launch, cfg_bad;

  logic             gen_active, gen_first, gen_last_i, gen_last_k;
  logic [IDX_W-1:0] gen_x_idx, gen_h_idx;

  logic             rd_v, rd_first, rd_last_i, rd_last_k, rd_xpad, rd_hpad;
  logic [W-1:0]     op_a, op_b;
  logic signed [ACC_W-1:0] mac_data;

  assign n_calc  = (len_q[SEQ_FIRST] > len_q[SEQ_SECOND]) ? len_q[SEQ_FIRST] : len_q[SEQ_SECOND];
  assign launch  = start && !busy && (n_calc != '0);
  assign cfg_bad = (cfg_len == '0) || (cfg_len > LEN_W'(MAX_LEN));

  assign buf_raddr[SEQ_FIRST]  = gen_x_idx;
  assign buf_raddr[SEQ_SECOND] = gen_h_idx;

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    assign buf_we[s] = smp_valid && !busy && (smp_sel == 1'(s)) && (wp_q[s] < len_q[s]);

    seq_buffer #(.W(W), .DEPTH(MAX_LEN), .AW(IDX_W)) buf_i (
      .clk   (clk),
      .we    (buf_we[s]),
      .waddr (wp_q[s][IDX_W-1:0]),
      .wdata (smp_data),
      .raddr (buf_raddr[s]),
      .rdata (buf_rdata[s])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        len_q[s] <= '0;
        wp_q[s]  <= '0;
      end else begin
        if (buf_we[s]) wp_q[s] <= wp_q[s] + LEN_W'(1);
        if (cfg_valid && !busy && !cfg_bad && (cfg_sel == 1'(s))) begin
          len_q[s] <= cfg_len;
          wp_q[s]  <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err   <= 1'b0;
      busy  <= 1'b0;
      n_reg <= '0;
    end else begin
      err <= cfg_valid && !busy && cfg_bad;
      if (rd_v && rd_last_i && rd_last_k) busy <= 1'b0;
      else if (launch) begin
        busy  <= 1'b1;
        n_reg <= n_calc;
      end
    end
  end

  index_gen #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)) gen_i (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .n      (n_calc),
    .active (gen_active),
    .x_idx  (gen_x_idx),
    .h_idx  (gen_h_idx),
    .first  (gen_first),
    .last_i (gen_last_i),
    .last_k (gen_last_k)
  );

  // read stage, aligned with the synchronous buffer output
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v      <= 1'b0;
      rd_first  <= 1'b0;
      rd_last_i <= 1'b0;
      rd_last_k <= 1'b0;
      rd_xpad   <= 1'b0;
      rd_hpad   <= 1'b0;
    end else begin
      rd_v      <= gen_active;
      rd_first  <= gen_first;
      rd_last_i <= gen_last_i;
      rd_last_k <= gen_last_k;
      rd_xpad   <= LEN_W'(gen_x_idx) >= len_q[SEQ_FIRST];
      rd_hpad   <= LEN_W'(gen_h_idx) >= len_q[SEQ_SECOND];
    end
  end

  assign op_a = rd_xpad ? '0 : buf_rdata[SEQ_FIRST];
  assign op_b = rd_hpad ? '0 : buf_rdata[SEQ_SECOND];

  mac_unit #(.W(W), .ACC_W(ACC_W)) mac_i (
    .clk       (clk),
    .rst       (rst),
    .in_v      (rd_v),
    .first     (rd_first),
    .last_i    (rd_last_i),
    .last_k    (rd_last_k),
    .a         (op_a),
    .b         (op_b),
    .out_valid (out_valid),
    .out_data  (mac_data),
    .out_last  (out_last)
  );

  assign out_data = mac_data;
endmodule

// File: rtl/circ_conv_checker.sv
module circ_conv_checker #(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cfg_valid,
  input logic             busy,
  input logic             err,
  input logic             out_valid,
  input logic             out_last,
  input logic [LEN_W-1:0] run_len
);
  logic [LEN_W:0] out_cnt;

  always_ff @(posedge clk) begin
    if (rst) out_cnt <= '0;
    else if (out_valid) out_cnt <= out_last ? '0 : out_cnt + 1'b1;
  end

  // R4: the final sample of a run is sample number N
  p_count_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> (out_cnt + 1'b1) == {1'b0, run_len});

  // R4: a run length lies in 1..MAX_LEN
  p_len_range_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len != '0) && (run_len <= LEN_W'(MAX_LEN)));

  // R3: err only follows a configuration write made while idle
  p_err_cause_r3: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(cfg_valid && !busy));

  // R7: busy rises only from an idle start, and the run length holds during a run
  p_busy_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  p_len_hold_r7: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(run_len));

  // R10: outputs only during a run; busy ends with the last sample
  p_valid_in_run_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));
  p_last_ends_r10: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid && !busy);
endmodule

bind circ_conv_engine circ_conv_checker #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cfg_valid (cfg_valid),
  .busy      (busy),
  .err       (err),
  .out_valid (out_valid),
  .out_last  (out_last),
  .run_len   (n_reg)
);

// File: tb/circ_conv_engine_tb_top.sv
module circ_conv_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W       = 8;
  localparam int MAX_LEN = 32;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int ACC_W   = 2 * W + $clog2(MAX_LEN);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_valid = 1'b0, cfg_sel = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic smp_valid = 1'b0, smp_sel = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic start = 1'b0;
  logic busy, err, out_valid, out_last;
  logic [ACC_W-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  int mx[MAX_LEN], mh[MAX_LEN];
  int lx = 0, lh = 0;
  int stage[MAX_LEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_conv_engine #(.W(W), .MAX_LEN(MAX_LEN)) dut_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel), .cfg_len(cfg_len),
    .smp_valid(smp_valid), .smp_sel(smp_sel), .smp_data(smp_data), .start(start),
    .busy(busy), .err(err), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cfg(input bit sel, input int len, output bit err_seen);
    cfg_valid = 1'b1; cfg_sel = sel; cfg_len = LEN_W'(len);
    @(negedge clk);
    cfg_valid = 1'b0;
    err_seen = err;
  endtask

  task automatic push(input bit sel, input int val);
    smp_valid = 1'b1; smp_sel = sel; smp_data = W'(val);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // R2: configure and fill one sequence from stage[], mirror it in the model
  task automatic load(input bit sel, input int len, input int pushes);
    bit e;
    do_cfg(sel, len, e);
    chk(e == 1'b0, "R2 valid length no err", int'(e), 0);
    for (int i = 0; i < pushes; i++) push(sel, stage[i]);
    for (int i = 0; i < len; i++) begin
      if (sel) mh[i] = stage[i]; else mx[i] = stage[i];
    end
    if (sel) lh = len; else lx = len;
  endtask

  task automatic run_check(input string name, input bit inject);
    int n, exp[MAX_LEN], got, cyc;
    bit done;
    n = (lx > lh) ? lx : lh;
    for (int k = 0; k < n; k++) begin
      exp[k] = 0;
      for (int i = 0; i < n; i++) begin
        int j, xv, hv;
        j  = (k - i + n) % n;
        xv = (i < lx) ? mx[i] : 0;
        hv = (j < lh) ? mh[j] : 0;
        exp[k] += xv * hv;
      end
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R4 run started ", name}, int'(busy), 1);
    got = 0; done = 0; cyc = 0;
    while (!done && cyc < 4000) begin
      if (out_valid) begin
        chk(got < n && int'($signed(out_data)) == exp[got], {"R5 sample ", name},
            int'($signed(out_data)), (got < n) ? exp[got] : 0);
        if (out_last) begin
          chk(got + 1 == n, {"R4 sample count ", name}, got + 1, n);
          chk(busy == 1'b0, {"R10 busy ends with last ", name}, int'(busy), 0);
          done = 1;
        end
        got++;
      end
      if (inject && cyc == 2) begin
        start = 1'b1; cfg_valid = 1'b1; cfg_sel = 1'b0; cfg_len = LEN_W'(5);
        smp_valid = 1'b1; smp_sel = 1'b1; smp_data = W'(99);
      end else begin
        start = 1'b0; cfg_valid = 1'b0; smp_valid = 1'b0;
      end
      if (inject && cyc == 3)
        chk(err == 1'b0, {"R7 no err while busy ", name}, int'(err), 0);
      @(negedge clk);
      cyc++;
    end
    chk(done, {"R4 run completed ", name}, int'(done), 1);
    repeat (3) begin
      chk(out_valid == 1'b0 && busy == 1'b0, {"R10 quiet after run ", name}, int'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(err == 1'b0, "R1 err after reset", int'(err), 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1 out_last after reset", int'(out_last), 0);
  endtask

  task automatic t_start_unconfigured;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) begin
      chk(busy == 1'b0 && out_valid == 1'b0, "R8 start ignored with zero lengths", int'(busy), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_example;
    int ref_y[4] = '{18, 16, 10, 16};
    stage[0] = 1; stage[1] = 2; stage[2] = 3; stage[3] = 4;
    load(1'b0, 4, 4);
    stage[0] = 1; stage[1] = 2; stage[2] = 3;
    load(1'b1, 3, 3);
    for (int k = 0; k < 4; k++) begin
      int s;
      s = 0;
      for (int i = 0; i < 4; i++) begin
        int j;
        j = (k - i + 4) % 4;
        s += mx[i] * ((j < 3) ? mh[j] : 0);
      end
      chk(s == ref_y[k], "R5 model matches worked example", s, ref_y[k]);
    end
    run_check("example 4x3", 1'b0);
  endtask

  task automatic t_second_longer;
    stage[0] = 5; stage[1] = -3;
    load(1'b0, 2, 2);
    for (int i = 0; i < 5; i++) stage[i] = i + 1;
    load(1'b1, 5, 5);
    run_check("second longer 2x5", 1'b0);
  endtask

  task automatic t_single;
    stage[0] = 7;  load(1'b0, 1, 1);
    stage[0] = -6; load(1'b1, 1, 1);
    run_check("length one", 1'b0);
  endtask

  task automatic t_full_mixed;
    for (int i = 0; i < MAX_LEN; i++) stage[i] = i - 16;
    load(1'b0, MAX_LEN, MAX_LEN);
    for (int i = 0; i < MAX_LEN; i++) stage[i] = (3 * i) % 17 - 8;
    load(1'b1, MAX_LEN, MAX_LEN);
    run_check("full length mixed", 1'b0);
  endtask

  task automatic t_extremes;
    for (int i = 0; i < MAX_LEN; i++) stage[i] = -128;
    load(1'b0, MAX_LEN, MAX_LEN);
    load(1'b1, MAX_LEN, MAX_LEN);
    run_check("R6 extreme negative", 1'b0);
    for (int i = 0; i < MAX_LEN; i++) stage[i] = 127;
    load(1'b1, MAX_LEN, MAX_LEN);
    run_check("R6 mixed extremes", 1'b0);
  endtask

  task automatic t_bad_lengths;
    bit e;
    stage[0] = 2; stage[1] = -4; stage[2] = 9;
    load(1'b0, 3, 3);
    stage[0] = 1; stage[1] = 3;
    load(1'b1, 2, 2);
    do_cfg(1'b0, 0, e);
    chk(e == 1'b1, "R3 err for length 0", int'(e), 1);
    do_cfg(1'b1, MAX_LEN + 1, e);
    chk(e == 1'b1, "R3 err for length MAX+1", int'(e), 1);
    do_cfg(1'b0, (1 << LEN_W) - 1, e);
    chk(e == 1'b1, "R3 err for largest code", int'(e), 1);
    chk(err == 1'b1 || err == 1'b0, "R3 err observed", int'(err), int'(err));
    @(negedge clk);
    chk(err == 1'b0, "R3 err is one cycle", int'(err), 0);
    run_check("R3 config unchanged after rejects", 1'b0);
  endtask

  task automatic t_busy_ignore;
    for (int i = 0; i < 6; i++) stage[i] = 2 * i - 5;
    load(1'b0, 6, 6);
    for (int i = 0; i < 4; i++) stage[i] = 4 - i;
    load(1'b1, 4, 4);
    run_check("R7 writes during run", 1'b1);
    run_check("R7 state kept after run", 1'b0);
  endtask

  task automatic t_extra_samples;
    stage[0] = 11; stage[1] = -7; stage[2] = 3;
    stage[3] = 50; stage[4] = 60; stage[5] = 70;
    load(1'b0, 3, 6);
    stage[0] = 2; stage[1] = 1; stage[2] = -1; stage[3] = 4;
    load(1'b1, 4, 4);
    run_check("R9 surplus samples dropped", 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start_unconfigured();
    t_example();
    t_second_longer();
    t_single();
    t_full_mixed();
    t_extremes();
    t_bad_lengths();
    t_busy_ignore();
    t_extra_samples();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule